// File: doc/BRIEF.md
# Byte-Stream Register DMA

This block moves a run of bytes from a wide 24-bit source address space into one register on a narrow peripheral bus. Software sets it up through a byte-wide configuration write port: a destination register number, a three-byte source pointer and a two-byte length. A write to the launch register with bit 0 set then starts the copy. The engine reads one byte from the source bus, then writes that byte to the peripheral register. It advances the source pointer and repeats until the programmed number of bytes has been moved.

Every byte of a transfer lands on the same peripheral address, so the block suits loading a data port that has its own auto-incrementing pointer behind it. The source pointer is left one past the last byte that was read. A second launch with only a new length therefore continues the stream where the previous one stopped.

Top module: `blkcopy_dma`

## Requirements
- R1: While reset is asserted, and after it is released with no launch, busy, src_req and per_we are all low.
- R2: Every peripheral write uses address {8'h21, dest}, where dest is the 8-bit value last written to configuration index 1.
- R3: The source pointer is loaded one byte at a time: index 2 sets bits 7:0, index 3 sets bits 15:8, index 4 sets bits 23:16. Each write leaves the other two bytes unchanged.
- R4: The length is loaded one byte at a time: index 5 sets bits 7:0 and index 6 sets bits 15:8, leaving the other byte unchanged. A launch moves exactly that many bytes.
- R5: A write to index 15 with bit 0 of the data set launches a transfer. A write to index 15 with bit 0 clear causes no source read and no peripheral write.
- R6: For each byte, src_req is held with a stable src_addr until src_rvalid is seen. In the next cycle exactly one peripheral write carries the byte that was read. src_req and per_we are never high together.
- R7: After each byte the source pointer advances by one, modulo 2^24. Its final value is kept, so the next launch continues from it.
- R8: Writes to configuration index 0 are accepted and change nothing in later transfers.
- R9: A launch with a length of zero performs no read and no write, and busy stays low.
- R10: busy rises in the cycle after a launch and falls after the last peripheral write. Configuration writes, including launch writes, made while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| busy | output | 1 | Transfer in progress |
| src_req | output | 1 | Source read request |
| src_addr | output | 24 | Source read address (current pointer) |
| src_rvalid | input | 1 | Source read data valid |
| src_rdata | input | 8 | Source read data |
| per_we | output | 1 | Peripheral write strobe |
| per_addr | output | 16 | Peripheral write address |
| per_wdata | output | 8 | Peripheral write data |

## Verification
The hardest cases to reach are writes that land while a transfer is running, and the pointer crossing the top of the 24-bit space. The bench slows the source with a three-cycle read latency so that a burst of new destination, pointer, length and launch writes all falls inside one transfer. The scoreboard still expects the original destination, and the next launch must resume from the undisturbed pointer. A separate run starts at 0xFFFFFE, so the expected read-address queue crosses through zero.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // Configuration register indices
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_DEST  = 1;
  localparam int unsigned IDX_SRC0  = 2;
  localparam int unsigned IDX_SIZE0 = 5;
  localparam int unsigned IDX_START = 15;

  // Upper byte of every peripheral write address
  localparam logic [7:0] PERIPH_PAGE = 8'h21;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned DEST_W = 8,
  parameter int unsigned CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              src_inc,
  output logic [DEST_W-1:0] dest_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [SIZE_W-1:0] size_o
);
  import dma_pkg::*;

  localparam int unsigned SRC_BYTES  = ADDR_W / 8;
  localparam int unsigned SIZE_BYTES = SIZE_W / 8;
  localparam logic [ADDR_W-1:0] SRC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [DEST_W-1:0] dest_q, dest_d;
  logic              dest_en;
  logic [ADDR_W-1:0] src_q, src_d, src_plus;
  logic              src_en;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [SRC_BYTES-1:0]  src_hit;
  logic [SIZE_BYTES-1:0] size_hit;

  // Destination register
  always_comb begin
    dest_en = wr_en && (int'(wr_idx) == int'(IDX_DEST));
    dest_d  = wr_data[DEST_W-1:0];
  end

  // Source pointer: byte lanes plus increment path
  assign src_plus = src_q + SRC_ONE;

  for (genvar k = 0; k < SRC_BYTES; k++) begin : g_src_lane
    localparam int LANE = int'(IDX_SRC0) + k;
    assign src_hit[k] = wr_en && (int'(wr_idx) == LANE);
    assign src_d[8*k +: 8] = src_hit[k] ? wr_data :
                             src_inc    ? src_plus[8*k +: 8] :
                                          src_q[8*k +: 8];
  end

  assign src_en = src_inc || (|src_hit);

  // Transfer length: byte lanes
  for (genvar k = 0; k < SIZE_BYTES; k++) begin : g_size_lane
    localparam int LANE = int'(IDX_SIZE0) + k;
    assign size_hit[k] = wr_en && (int'(wr_idx) == LANE);
    assign size_d[8*k +: 8] = size_hit[k] ? wr_data : size_q[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      src_q  <= '0;
      size_q <= '0;
    end else begin
      if (dest_en)      dest_q <= dest_d;
      if (src_en)       src_q  <= src_d;
      if (|size_hit)    size_q <= size_d;
    end
  end

  assign dest_o = dest_q;
  assign src_o  = src_q;
  assign size_o = size_q;
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              src_inc_o
);
  import dma_pkg::*;

  localparam logic [SIZE_W-1:0] CNT_ONE = {{(SIZE_W-1){1'b0}}, 1'b1};

  seq_state_e        state_q, state_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              inc;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    hold_d  = hold_q;
    hold_en = 1'b0;
    inc     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && (size_i != '0)) begin
          state_d = ST_READ;
          cnt_d   = size_i;
          cnt_en  = 1'b1;
        end
      end
      ST_READ: begin
        if (rvalid_i) begin
          hold_d  = rdata_i;
          hold_en = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        inc     = 1'b1;
        cnt_d   = cnt_q - CNT_ONE;
        cnt_en  = 1'b1;
        state_d = (cnt_q == CNT_ONE) ? ST_IDLE : ST_READ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign rd_req_o  = (state_q == ST_READ);
  assign wr_en_o   = (state_q == ST_WRITE);
  assign wr_data_o = hold_q;
  assign src_inc_o = inc;
endmodule

// File: rtl/blkcopy_dma.sv
module blkcopy_dma #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic              busy,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_rvalid,
  input  logic [7:0]        src_rdata,
  output logic              per_we,
  output logic [15:0]       per_addr,
  output logic [7:0]        per_wdata
);
  import dma_pkg::*;

  localparam int unsigned DEST_W = 8;

  logic              rst_n_int;
  logic              reg_we;
  logic              launch;
  logic              src_inc;
  logic [DEST_W-1:0] dest;
  logic [SIZE_W-1:0] size;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Writes are dropped while a transfer runs
  always_comb begin
    reg_we = cfg_we && !busy;
    launch = reg_we && (int'(cfg_idx) == int'(IDX_START)) && cfg_wdata[0];
  end

  dma_regs #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .DEST_W (DEST_W),
    .CFG_AW (CFG_AW)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (reg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .src_inc (src_inc),
    .dest_o  (dest),
    .src_o   (src_addr),
    .size_o  (size)
  );

  dma_seq #(
    .SIZE_W (SIZE_W),
    .DATA_W (8)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start_i   (launch),
    .size_i    (size),
    .rvalid_i  (src_rvalid),
    .rdata_i   (src_rdata),
    .busy_o    (busy),
    .rd_req_o  (src_req),
    .wr_en_o   (per_we),
    .wr_data_o (per_wdata),
    .src_inc_o (src_inc)
  );

  assign per_addr = {PERIPH_PAGE, dest};
endmodule

// File: rtl/blkcopy_dma_chk.sv
module blkcopy_dma_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              src_req,
  input logic [ADDR_W-1:0] src_addr,
  input logic              src_rvalid,
  input logic              per_we,
  input logic [15:0]       per_addr
);
  localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_req && per_we));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_rvalid) |=> (src_req && $stable(src_addr)));

  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_we) |-> $past(src_req && src_rvalid));

  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |=> !per_we);

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |=> (src_addr == $past(src_addr) + A_ONE));

  assert_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |-> (per_addr[15:8] == 8'h21));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!src_req && !per_we));
endmodule

bind blkcopy_dma blkcopy_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .src_req    (src_req),
  .src_addr   (src_addr),
  .src_rvalid (src_rvalid),
  .per_we     (per_we),
  .per_addr   (per_addr)
);

// File: tb/blkcopy_dma_tb.sv
`timescale 1ns/1ps
module blkcopy_dma_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic        busy;
  logic        src_req;
  logic [23:0] src_addr;
  logic        src_rvalid;
  logic [7:0]  src_rdata;
  logic        per_we;
  logic [15:0] per_addr;
  logic [7:0]  per_wdata;

  int n_checks = 0;
  int n_errs   = 0;
  int cycles   = 0;

  // Bench model of the configuration state
  logic [7:0]  m_dest;
  logic [23:0] m_src;
  logic [15:0] m_size;

  // Scoreboard queues
  logic [23:0] rd_q[$];
  logic [23:0] wr_q[$];

  // Source memory model
  int lat_cfg;
  int lat_cnt;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  blkcopy_dma u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .busy       (busy),
    .src_req    (src_req),
    .src_addr   (src_addr),
    .src_rvalid (src_rvalid),
    .src_rdata  (src_rdata),
    .per_we     (per_we),
    .per_addr   (per_addr),
    .per_wdata  (per_wdata)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  assign src_rvalid = src_req && (lat_cnt == lat_cfg);
  assign src_rdata  = mem_byte(src_addr);

  always @(posedge clk) begin
    if (!src_req || src_rvalid) lat_cnt <= 0;
    else                        lat_cnt <= lat_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  // Monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n && src_req && src_rvalid) begin
      if (rd_q.size() == 0) begin
        check(1'b0, "R5/R10", "unexpected source read", longint'(src_addr), 0);
      end else begin
        logic [23:0] e;
        e = rd_q.pop_front();
        check(src_addr == e, "R3/R7", "read address", longint'(src_addr), longint'(e));
      end
    end
    if (rst_n && per_we) begin
      if (wr_q.size() == 0) begin
        check(1'b0, "R5/R10", "unexpected peripheral write", longint'(per_addr), 0);
      end else begin
        logic [23:0] e;
        e = wr_q.pop_front();
        check({per_addr, per_wdata} == e, "R2/R6", "peripheral write {addr,data}",
              longint'({per_addr, per_wdata}), longint'(e));
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      check(1'b0, "WDOG", "watchdog expired", cycles, 150000);
      finish_run();
    end
  end

  task automatic cfg_write(input logic [3:0] idx, input logic [7:0] val);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_idx   = idx;
    cfg_wdata = val;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Write while idle and mirror it in the model
  task automatic prog(input logic [3:0] idx, input logic [7:0] val);
    cfg_write(idx, val);
    case (idx)
      4'd1: m_dest = val;
      4'd2: m_src[7:0]   = val;
      4'd3: m_src[15:8]  = val;
      4'd4: m_src[23:16] = val;
      4'd5: m_size[7:0]  = val;
      4'd6: m_size[15:8] = val;
      default: ;
    endcase
  endtask

  // Driver: push expected items for one launch
  task automatic expect_xfer();
    for (int i = 0; i < int'(m_size); i++) begin
      rd_q.push_back(m_src);
      wr_q.push_back({8'h21, m_dest, mem_byte(m_src)});
      m_src = m_src + 24'd1;
    end
  endtask

  task automatic wait_done(input string req);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(rd_q.size() == 0, req, "reads left over", rd_q.size(), 0);
    check(wr_q.size() == 0, req, "writes left over", wr_q.size(), 0);
  endtask

  task automatic run(input string req);
    expect_xfer();
    cfg_write(4'd15, 8'h01);
    check(busy == (m_size != 0), "R10", "busy after launch", busy, (m_size != 0));
    wait_done(req);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    lat_cfg = 0;
    m_dest = '0; m_src = '0; m_size = '0;
    repeat (4) @(negedge clk);
    check(!busy && !src_req && !per_we, "R1", "outputs in reset",
          {busy, src_req, per_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !src_req && !per_we, "R1", "outputs after reset",
          {busy, src_req, per_we}, 0);

    // R2 R5 basic transfer, zero-latency source
    prog(4'd1, 8'h18);
    prog(4'd2, 8'h56); prog(4'd3, 8'h34); prog(4'd4, 8'h12);
    prog(4'd5, 8'h04); prog(4'd6, 8'h00);
    run("R5");

    // R8 control writes do nothing; R7 pointer continues; slow source
    lat_cfg = 3;
    prog(4'd0, 8'hFF);
    prog(4'd5, 8'h03);
    run("R8");

    // R5 launch with bit 0 clear
    cfg_write(4'd15, 8'hFE);
    check(!busy, "R5", "busy after bit0-clear launch", busy, 0);
    repeat (6) @(negedge clk);
    check(!busy, "R5", "still idle", busy, 0);

    // R9 zero length
    prog(4'd5, 8'h00);
    run("R9");
    repeat (4) @(negedge clk);
    check(!busy, "R9", "idle after zero length", busy, 0);

    // R3 only the high pointer byte changes
    lat_cfg = 1;
    prog(4'd4, 8'h9A);
    prog(4'd5, 8'h02);
    prog(4'd1, 8'h3C);
    run("R3");
    prog(4'd3, 8'hE1);
    run("R3");

    // R7 wrap through zero
    prog(4'd2, 8'hFE); prog(4'd3, 8'hFF); prog(4'd4, 8'hFF);
    prog(4'd5, 8'h04);
    run("R7");
    prog(4'd5, 8'h01);
    run("R7");

    // R10 writes while busy are dropped
    lat_cfg = 3;
    prog(4'd5, 8'h08);
    expect_xfer();
    cfg_write(4'd15, 8'h01);
    check(busy, "R10", "busy after launch", busy, 1);
    cfg_write(4'd1, 8'h77);
    cfg_write(4'd2, 8'h00);
    cfg_write(4'd5, 8'h01);
    cfg_write(4'd6, 8'h05);
    cfg_write(4'd15, 8'h01);
    check(busy, "R10", "still busy during writes", busy, 1);
    wait_done("R10");
    check(!busy, "R10", "busy low after last write", busy, 0);
    prog(4'd5, 8'h02);
    run("R10");

    // R4 high length byte, lower byte kept
    lat_cfg = 0;
    prog(4'd6, 8'h01);
    run("R4");

    finish_run();
  end
endmodule